// File: doc/BRIEF.md
# Auto-Masking Prioritized Interrupt Controller

This block collects a parameterized set of level-sensitive hardware interrupt lines, combines each with a software trigger bit, and distributes the result to a parameterized number of CPUs. Each CPU has one interrupt output and one event register. Reading the event register returns the most urgent source waiting for that CPU and acknowledges it in the same clock cycle. A hardware source is acknowledged by setting its mask bit. An inter-processor interrupt is acknowledged by clearing it. Software re-enables a hardware source by clearing its mask bit once it has serviced that source.

Every CPU also owns two inter-processor interrupt slots. Either slot can be raised by any CPU through a bitmap write. The register port is a single synchronous access port. The bus master identifies itself on `bus_cpu`. A local view at the bottom of the map resolves to the accessing CPU. An explicit per-CPU view lets any master reach any CPU's view registers. The port carries one access per cycle, and the event read and its acknowledge take effect at the same clock edge. Two CPUs therefore can never both claim the same source.

Top module: `intc_automask`

## Requirements
- R1: After synchronous active-low reset, every mask bit is 1, every software trigger and IPI slot is 0, every affinity bit is 1, every `irq_out` bit is 0 and every event read returns 0.
- R2: A source's request is its `hw_irq` line ORed with its software trigger bit. The request is level-sensitive and is pending only while one of the two is high.
- R3: A source whose mask bit is 1 never contributes to any CPU's `irq_out` or event value.
- R4: Affinity word `3<<10 | n` holds, in bits [NUM_CPU-1:0], the set of CPUs allowed to receive source n. A source is invisible to any CPU whose affinity bit is 0.
- R5: Among the pending hardware sources of one CPU, the lowest source number wins.
- R6: The event value is `{kind[17:16], number[15:0]}` with the upper bits zero. Kind 1 means hardware and kind 2 means IPI. The value is all zero when nothing is pending for the CPU.
- R7: A read of an event register that returns a hardware event sets that source's mask bit at the same clock edge.
- R8: The IPI raise register (view offset 1) sets slot 0 of CPU c for `wdata[c]` and slot 1 of CPU c for `wdata[16+c]`. The IPI clear register (offset 2) clears slot 0 or slot 1 of the view's CPU for `wdata[0]` or `wdata[1]`. IPI status (offset 3) reads `{slot1, slot0}`. Slot 0 outranks slot 1, and both outrank any hardware source. They read as number 0 and number 1. Reading an IPI event clears that slot.
- R9: Address `0x000 | off` reaches the view of `bus_cpu`. Address `1<<10 | c<<4 | off` reaches the view of CPU c. Offset 0 is the event register.
- R10: Bank address `2<<10 | f<<6 | w` covers sources 32w to 32w+31. Function f=0 is mask set, f=1 is mask clear, f=2 is software set, f=3 is software clear, and f=4 reads the raw lines. Writes act on the 1-bits only, and reads of f=0/1 and f=2/3 return the mask and software bits.
- R11: `irq_out[c]` is high exactly when CPU c has a pending IPI slot or an unmasked, affinity-enabled request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_irq | input | NUM_IRQ | Level-sensitive hardware request lines, synchronous to clk |
| bus_cpu | input | CPU_W | Index of the CPU making the current access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; an event read acknowledges at the clock edge |
| bus_addr | input | 12 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for the addressed register |
| irq_out | output | NUM_CPU | Per-CPU interrupt request |

## Verification
The bench targets the acknowledge: a design that returned the winner but failed to mask it would keep `irq_out` high and deliver the same source again on the next read. Priority is exercised with several sources pending at once and affinity limited to one CPU, so an encoder that scanned from the top or ignored affinity would hand the wrong number to the wrong CPU. IPIs are raised together with a pending hardware source, so a design that ranked them below hardware, or that cleared the wrong slot on a read, shows a different order of events. The per-CPU view is read from a different `bus_cpu` than the target, which catches a decoder that always used the requester.

// File: rtl/intc_pkg.sv
// Package: shared constants and decode record for the interrupt controller.
// Assumes a 12-bit word address split into a 2-bit region and a 10-bit body.
package intc_pkg;

    localparam int ADDR_W = 12;

    // Event kind codes placed in bits [17:16] of an event value
    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_HW   = 2'd1,
        EV_IPI  = 2'd2
    } ev_kind_e;

    localparam int KIND_LSB = 16;

    // Address regions
    localparam logic [1:0] RG_LOCAL = 2'd0;
    localparam logic [1:0] RG_CPU   = 2'd1;
    localparam logic [1:0] RG_BANK  = 2'd2;
    localparam logic [1:0] RG_AFF   = 2'd3;

    // View register offsets
    localparam logic [3:0] VO_EVENT   = 4'd0;
    localparam logic [3:0] VO_IPI_SET = 4'd1;
    localparam logic [3:0] VO_IPI_CLR = 4'd2;
    localparam logic [3:0] VO_IPI_STS = 4'd3;

    // Bank functions
    localparam logic [3:0] BF_MASK_SET = 4'd0;
    localparam logic [3:0] BF_MASK_CLR = 4'd1;
    localparam logic [3:0] BF_SW_SET   = 4'd2;
    localparam logic [3:0] BF_SW_CLR   = 4'd3;
    localparam logic [3:0] BF_HW_STS   = 4'd4;

    // Decoded address fields
    typedef struct packed {
        logic       is_local;
        logic       is_cpu;
        logic       is_bank;
        logic       is_aff;
        logic [5:0] cpu;
        logic [3:0] off;
        logic [3:0] fn;
        logic [5:0] word;
        logic [9:0] idx;
    } dec_t;

endpackage

// File: rtl/intc_addr_dec.sv
// Address decoder: splits a word address into region flags and fields.
// Assumes the region layout of intc_pkg; purely combinational.
module intc_addr_dec
    import intc_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);

    // Region select and field extraction
    always_comb begin
        dec          = '0;
        dec.is_local = (addr[11:10] == RG_LOCAL);
        dec.is_cpu   = (addr[11:10] == RG_CPU);
        dec.is_bank  = (addr[11:10] == RG_BANK);
        dec.is_aff   = (addr[11:10] == RG_AFF);
        dec.cpu      = addr[9:4];
        dec.off      = addr[3:0];
        dec.fn       = addr[9:6];
        dec.word     = addr[5:0];
        dec.idx      = addr[9:0];
    end

endmodule

// File: rtl/intc_ffs.sv
// Find-first-set: reports the lowest set bit of a request vector.
// Assumes W >= 2; idx is zero when nothing is set.
module intc_ffs #(
    parameter int W = 64,
    localparam int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    // Scan from the top so the lowest set bit is the last assignment
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/intc_cpu_arb.sv
// Per-CPU arbiter: ranks this CPU's IPI slots above its hardware sources
// and forms the event value and the interrupt output.
// Assumes live already has masked sources removed.
module intc_cpu_arb
    import intc_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    localparam int IRQ_W = $clog2(NUM_IRQ)
) (
    input  logic [NUM_IRQ-1:0] live,
    input  logic [NUM_IRQ-1:0] aff,
    input  logic [1:0]         ipi,
    output logic [31:0]        ev_word,
    output logic               irq
);

    logic [NUM_IRQ-1:0] visible;
    logic               hw_found;
    logic [IRQ_W-1:0]   hw_idx;

    // Sources this CPU may take
    assign visible = live & aff;

    intc_ffs #(.W(NUM_IRQ)) u_ffs (
        .req   (visible),
        .found (hw_found),
        .idx   (hw_idx)
    );

    // Event value: slot 0, then slot 1, then the lowest hardware source
    always_comb begin
        ev_word = '0;
        if (ipi[0]) begin
            ev_word[KIND_LSB +: 2] = EV_IPI;
        end else if (ipi[1]) begin
            ev_word[KIND_LSB +: 2] = EV_IPI;
            ev_word[0]             = 1'b1;
        end else if (hw_found) begin
            ev_word[KIND_LSB +: 2] = EV_HW;
            ev_word[IRQ_W-1:0]     = hw_idx;
        end
    end

    // Request output from the raw OR of everything this CPU may see
    assign irq = (|visible) | (|ipi);

endmodule

// File: rtl/intc_automask.sv
// Interrupt controller top: holds mask, software trigger, affinity and IPI
// state, decodes the register port and acknowledges on event reads.
// Assumes one access per cycle, hw_irq synchronous to clk, NUM_CPU <= 16,
// NUM_IRQ <= 1024 and 2 <= NUM_CPU.
module intc_automask
    import intc_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_CPU = 4,
    localparam int CPU_W = $clog2(NUM_CPU),
    localparam int IRQ_W = $clog2(NUM_IRQ)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] hw_irq,
    input  logic [CPU_W-1:0]   bus_cpu,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [NUM_CPU-1:0] irq_out
);

    dec_t dec;

    logic [NUM_IRQ-1:0]              mask_q, mask_d;
    logic [NUM_IRQ-1:0]              sw_q, sw_d;
    logic [NUM_CPU-1:0][NUM_IRQ-1:0] aff_q, aff_d;
    logic [NUM_CPU-1:0][1:0]         ipi_q, ipi_d;

    logic [NUM_IRQ-1:0]              live;
    logic [NUM_CPU-1:0][31:0]        ev_word;

    logic [5:0]       tgt_full;
    logic [CPU_W-1:0] tgt_cpu;
    logic             view_ok;
    logic [31:0]      ev_sel;
    logic             ev_rd;
    logic             hw_ack;
    logic             ipi_ack;
    logic             bank_wr;
    logic [IRQ_W-1:0] ev_num;

    intc_addr_dec u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    // Target CPU of a view access
    always_comb begin
        tgt_full = dec.is_local ? 6'(bus_cpu) : dec.cpu;
        view_ok  = (dec.is_local || dec.is_cpu) && (int'(tgt_full) < NUM_CPU);
        tgt_cpu  = tgt_full[CPU_W-1:0];
    end

    // Effective unmasked requests
    assign live = (hw_irq | sw_q) & ~mask_q;

    generate
        for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
            intc_cpu_arb #(.NUM_IRQ(NUM_IRQ)) u_arb (
                .live    (live),
                .aff     (aff_q[c]),
                .ipi     (ipi_q[c]),
                .ev_word (ev_word[c]),
                .irq     (irq_out[c])
            );
        end
    endgenerate

    // Selected event and acknowledge strobes
    always_comb begin
        ev_sel  = view_ok ? ev_word[tgt_cpu] : '0;
        ev_num  = ev_sel[IRQ_W-1:0];
        ev_rd   = bus_rd && view_ok && (dec.off == VO_EVENT);
        hw_ack  = ev_rd && (ev_sel[KIND_LSB +: 2] == EV_HW);
        ipi_ack = ev_rd && (ev_sel[KIND_LSB +: 2] == EV_IPI);
        bank_wr = bus_wr && dec.is_bank;
    end

    // Mask next state: bank writes, then the acknowledge
    always_comb begin
        mask_d = mask_q;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (bank_wr && dec.word == 6'(i / 32) && bus_wdata[i % 32]) begin
                if (dec.fn == BF_MASK_SET) mask_d[i] = 1'b1;
                if (dec.fn == BF_MASK_CLR) mask_d[i] = 1'b0;
            end
            if (hw_ack && ev_num == IRQ_W'(i)) mask_d[i] = 1'b1;
        end
    end

    // Software trigger next state
    always_comb begin
        sw_d = sw_q;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (bank_wr && dec.word == 6'(i / 32) && bus_wdata[i % 32]) begin
                if (dec.fn == BF_SW_SET) sw_d[i] = 1'b1;
                if (dec.fn == BF_SW_CLR) sw_d[i] = 1'b0;
            end
        end
    end

    // Affinity next state: one source's CPU set per write
    always_comb begin
        aff_d = aff_q;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (bus_wr && dec.is_aff && dec.idx == 10'(i)) begin
                for (int c = 0; c < NUM_CPU; c++) aff_d[c][i] = bus_wdata[c];
            end
        end
    end

    // IPI next state: clear, then acknowledge, then raise
    always_comb begin
        ipi_d = ipi_q;
        for (int c = 0; c < NUM_CPU; c++) begin
            if (bus_wr && view_ok && dec.off == VO_IPI_CLR && tgt_cpu == CPU_W'(c)) begin
                if (bus_wdata[0]) ipi_d[c][0] = 1'b0;
                if (bus_wdata[1]) ipi_d[c][1] = 1'b0;
            end
            if (ipi_ack && tgt_cpu == CPU_W'(c)) ipi_d[c][ev_sel[0]] = 1'b0;
            if (bus_wr && view_ok && dec.off == VO_IPI_SET) begin
                if (bus_wdata[c])      ipi_d[c][0] = 1'b1;
                if (bus_wdata[16 + c]) ipi_d[c][1] = 1'b1;
            end
        end
    end

    // State registers with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
            sw_q   <= '0;
            aff_q  <= '1;
            ipi_q  <= '0;
        end else begin
            mask_q <= mask_d;
            sw_q   <= sw_d;
            aff_q  <= aff_d;
            ipi_q  <= ipi_d;
        end
    end

    // Read data multiplexer
    always_comb begin
        bus_rdata = '0;
        if (view_ok) begin
            case (dec.off)
                VO_EVENT:   bus_rdata = ev_sel;
                VO_IPI_STS: bus_rdata[1:0] = ipi_q[tgt_cpu];
                default:    bus_rdata = '0;
            endcase
        end else if (dec.is_bank) begin
            for (int i = 0; i < NUM_IRQ; i++) begin
                if (dec.word == 6'(i / 32)) begin
                    case (dec.fn)
                        BF_MASK_SET, BF_MASK_CLR: bus_rdata[i % 32] = mask_q[i];
                        BF_SW_SET, BF_SW_CLR:     bus_rdata[i % 32] = sw_q[i];
                        BF_HW_STS:                bus_rdata[i % 32] = hw_irq[i];
                        default:                  bus_rdata[i % 32] = 1'b0;
                    endcase
                end
            end
        end else if (dec.is_aff) begin
            for (int i = 0; i < NUM_IRQ; i++) begin
                if (dec.idx == 10'(i)) begin
                    for (int c = 0; c < NUM_CPU; c++) bus_rdata[c] = aff_q[c][i];
                end
            end
        end
    end

endmodule

// File: rtl/intc_automask_chk.sv
// Checker: temporal properties of the interrupt controller, bound to the top.
// Assumes the internal names of intc_automask.
module intc_automask_chk
    import intc_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_CPU = 4,
    localparam int CPU_W = $clog2(NUM_CPU),
    localparam int IRQ_W = $clog2(NUM_IRQ)
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      bus_wr,
    input logic [NUM_CPU-1:0]        irq_out,
    input logic [NUM_CPU-1:0][31:0]  ev_word,
    input logic [31:0]               ev_sel,
    input logic                      ev_rd,
    input logic [CPU_W-1:0]          tgt_cpu,
    input logic [NUM_IRQ-1:0]        mask_q,
    input logic [NUM_CPU-1:0][1:0]   ipi_q
);

    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ((&mask_q) && irq_out == '0 && ipi_q == '0));

    a_r7_ack_masks: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rd && ev_sel[KIND_LSB +: 2] == EV_HW) |=> mask_q[$past(ev_sel[IRQ_W-1:0])]);

    a_r8_ack_clears_ipi: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rd && !bus_wr && ev_sel[KIND_LSB +: 2] == EV_IPI)
        |=> !ipi_q[$past(tgt_cpu)][$past(ev_sel[0])]);

    generate
        for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
            a_r11_out_vs_event: assert property (@(posedge clk) disable iff (!rst_n)
                irq_out[c] == (ev_word[c][KIND_LSB +: 2] != EV_NONE));

            a_r6_kind_legal: assert property (@(posedge clk) disable iff (!rst_n)
                ev_word[c][KIND_LSB +: 2] != 2'b11);

            a_r6_none_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
                (ev_word[c][KIND_LSB +: 2] == EV_NONE) |-> (ev_word[c] == '0));
        end
    endgenerate

endmodule

bind intc_automask intc_automask_chk #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_wr  (bus_wr),
    .irq_out (irq_out),
    .ev_word (ev_word),
    .ev_sel  (ev_sel),
    .ev_rd   (ev_rd),
    .tgt_cpu (tgt_cpu),
    .mask_q  (mask_q),
    .ipi_q   (ipi_q)
);

// File: tb/tb_intc_automask.sv
// Bench: behavioural reference model compared on every clock.
module tb_intc_automask;

    localparam int NI = 64;
    localparam int NC = 4;
    localparam int CW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NI-1:0] hw_irq = '0;
    logic [CW-1:0] bus_cpu = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NC-1:0] irq_out;

    int n_checks = 0;
    int n_fail   = 0;

    // Reference state
    bit m_hw   [NI];
    bit m_mask [NI];
    bit m_sw   [NI];
    bit m_aff  [NC][NI];
    bit m_ipi  [NC][2];

    always #10 clk = ~clk;

    intc_automask #(.NUM_IRQ(NI), .NUM_CPU(NC)) dut (
        .clk(clk), .rst_n(rst_n), .hw_irq(hw_irq), .bus_cpu(bus_cpu),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    function automatic int a_local(int off); return off; endfunction
    function automatic int a_view(int c, int off); return (1 << 10) | (c << 4) | off; endfunction
    function automatic int a_bank(int f, int w); return (2 << 10) | (f << 6) | w; endfunction
    function automatic int a_aff(int n); return (3 << 10) | n; endfunction

    function automatic logic [31:0] m_event(int c);
        if (m_ipi[c][0]) return 32'h0002_0000;
        if (m_ipi[c][1]) return 32'h0002_0001;
        for (int i = 0; i < NI; i++)
            if ((m_hw[i] || m_sw[i]) && !m_mask[i] && m_aff[c][i]) return 32'h0001_0000 | i;
        return 32'h0;
    endfunction

    function automatic logic [NC-1:0] m_irq();
        logic [NC-1:0] r = '0;
        for (int c = 0; c < NC; c++) r[c] = (m_event(c) != 0);
        return r;
    endfunction

    function automatic int m_tgt(int cpu, int a);
        if ((a >> 10) == 0) return cpu;
        if ((a >> 10) == 1) return (a >> 4) & 63;
        return -1;
    endfunction

    function automatic logic [31:0] m_read(int cpu, int a);
        logic [31:0] r = '0;
        int t = m_tgt(cpu, a);
        if (t >= 0 && t < NC) begin
            if ((a & 15) == 0) r = m_event(t);
            if ((a & 15) == 3) r = {30'b0, m_ipi[t][1], m_ipi[t][0]};
        end else if ((a >> 10) == 2) begin
            for (int b = 0; b < 32; b++) begin
                int n = (a & 63) * 32 + b;
                if (n < NI) begin
                    case ((a >> 6) & 15)
                        0, 1: r[b] = m_mask[n];
                        2, 3: r[b] = m_sw[n];
                        4:    r[b] = m_hw[n];
                        default: r[b] = 1'b0;
                    endcase
                end
            end
        end else if ((a >> 10) == 3) begin
            if ((a & 1023) < NI)
                for (int c = 0; c < NC; c++) r[c] = m_aff[c][a & 1023];
        end
        return r;
    endfunction

    task automatic m_apply(int cpu, bit wr, bit rd, int a, logic [31:0] wd);
        int t = m_tgt(cpu, a);
        bit vok = (t >= 0 && t < NC);
        logic [31:0] ev = (rd && vok && (a & 15) == 0) ? m_event(t) : 32'h0;
        if (wr && (a >> 10) == 2) begin
            for (int b = 0; b < 32; b++) begin
                int n = (a & 63) * 32 + b;
                if (n < NI && wd[b]) begin
                    case ((a >> 6) & 15)
                        0: m_mask[n] = 1;
                        1: m_mask[n] = 0;
                        2: m_sw[n] = 1;
                        3: m_sw[n] = 0;
                        default: ;
                    endcase
                end
            end
        end
        if (wr && (a >> 10) == 3 && (a & 1023) < NI)
            for (int c = 0; c < NC; c++) m_aff[c][a & 1023] = wd[c];
        if (wr && vok && (a & 15) == 2) begin
            if (wd[0]) m_ipi[t][0] = 0;
            if (wd[1]) m_ipi[t][1] = 0;
        end
        if (ev[17:16] == 2'd1) m_mask[ev[15:0]] = 1;
        if (ev[17:16] == 2'd2) m_ipi[t][ev[0]] = 0;
        if (wr && vok && (a & 15) == 1)
            for (int c = 0; c < NC; c++) begin
                if (wd[c])      m_ipi[c][0] = 1;
                if (wd[16 + c]) m_ipi[c][1] = 1;
            end
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One bus cycle: drive after the falling edge, compare, then advance the model
    task automatic cyc(int cpu, bit wr, bit rd, int a, logic [31:0] wd, string tag);
        @(negedge clk);
        for (int i = 0; i < NI; i++) hw_irq[i] = m_hw[i];
        bus_cpu = CW'(cpu); bus_wr = wr; bus_rd = rd;
        bus_addr = 12'(a); bus_wdata = wd;
        #5;
        check("R11 irq_out", 32'(irq_out), 32'(m_irq()));
        if (rd) check(tag, bus_rdata, m_read(cpu, a));
        m_apply(cpu, wr, rd, a, wd);
    endtask

    task automatic wr_reg(int cpu, int a, logic [31:0] wd);
        cyc(cpu, 1, 0, a, wd, "");
    endtask

    task automatic rd_reg(int cpu, int a, string tag);
        cyc(cpu, 0, 1, a, 32'h0, tag);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        for (int i = 0; i < NI; i++) begin
            m_hw[i] = 0; m_mask[i] = 1; m_sw[i] = 0;
            for (int c = 0; c < NC; c++) m_aff[c][i] = 1;
        end
        for (int c = 0; c < NC; c++) begin m_ipi[c][0] = 0; m_ipi[c][1] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd_reg(0, a_bank(0, 0), "R1 mask word0");
        rd_reg(0, a_bank(2, 1), "R1 sw word1");
        rd_reg(1, a_aff(17), "R1 affinity");
        rd_reg(0, a_local(0), "R1 R6 empty event");

        // R3: masked line stays invisible
        m_hw[5] = 1;
        cyc(0, 0, 0, 0, 0, "");
        rd_reg(0, a_local(0), "R3 masked event");
        rd_reg(0, a_bank(4, 0), "R10 raw lines");

        // R10: clear mask bit 5
        wr_reg(0, a_bank(1, 0), 32'h20);
        rd_reg(0, a_bank(0, 0), "R10 mask after clear");

        // R6 R7: acknowledge from CPU 1
        rd_reg(1, a_local(0), "R6 hw event");
        rd_reg(1, a_local(0), "R7 masked after ack");
        rd_reg(2, a_bank(0, 0), "R7 mask bit set");

        // R4 R5 R2: several sources, restricted affinity
        m_hw[9] = 1;
        wr_reg(0, a_aff(5), 32'h4);
        rd_reg(0, a_aff(5), "R4 affinity readback");
        wr_reg(0, a_bank(2, 1), 32'h100);
        rd_reg(0, a_bank(3, 1), "R10 sw readback");
        wr_reg(0, a_bank(1, 0), 32'h220);
        wr_reg(0, a_bank(1, 1), 32'h100);
        rd_reg(0, a_local(0), "R4 R5 cpu0 gets 9");
        rd_reg(0, a_view(2, 0), "R5 R9 cpu2 gets 5 via view");
        rd_reg(1, a_view(3, 0), "R2 R9 cpu3 gets sw 40");

        // R2: dropping the line and the trigger ends the request
        m_hw[9] = 0;
        wr_reg(0, a_bank(1, 0), 32'h200);
        wr_reg(0, a_bank(1, 1), 32'h100);
        cyc(0, 0, 0, 0, 0, "");
        wr_reg(0, a_bank(3, 1), 32'h100);
        rd_reg(3, a_local(0), "R2 level released");

        // R8: IPIs outrank hardware, slot 0 before slot 1
        wr_reg(0, a_bank(1, 0), 32'h20);
        wr_reg(0, a_local(1), 32'h0004_0004);
        rd_reg(2, a_local(3), "R8 ipi status");
        rd_reg(2, a_local(0), "R8 slot0 first");
        rd_reg(2, a_local(0), "R8 slot1 next");
        rd_reg(2, a_local(0), "R8 hw after ipi");
        wr_reg(1, a_local(1), 32'h0002_0001);
        wr_reg(3, a_view(1, 2), 32'h2);
        rd_reg(0, a_view(1, 3), "R8 R9 clear via view");
        rd_reg(0, a_local(0), "R8 cpu0 slot0");
        rd_reg(0, a_local(0), "R8 cpu0 empty");

        repeat (3) cyc(0, 0, 0, 0, 0, "");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule